// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block drives the open-drain clock and data lines of an I2C master through two operations that close a byte transfer. The first is clocking out a single acknowledge bit (ACK or NACK) after the master has received a byte. The second is producing a STOP condition to release the bus. Software starts an operation with a one-cycle request strobe. The request for an acknowledge carries the bit value to send.

Timing comes from an internal down-counter that reloads from a programmable value. Every phase waits for the real line level, read back through a synchronizer, before it moves on. A slave that holds SCL low therefore lengthens the high phase instead of cutting it short.

The block keeps a sticky completion flag, a stop-observed status bit and a sticky write-collision flag. It also holds the transmit buffer register and refuses writes to it while an operation is running.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: An accepted acknowledge request pulls SCL low and drives SDA from the latched data bit for the whole operation. A data bit of 0 pulls SDA low (ACK) and 1 releases it (NACK). The low phase times reload+1 clocks, counted from the first cycle SCL reads low through the synchronizer. If SCL was already held low, the low phase is exactly reload+1 cycles. If SCL was released, SYNC_STAGES cycles are added.
- R2: SCL is then released. The high phase of reload+1 clocks starts only once SCL reads high through the SYNC_STAGES-deep synchronizer, so a slave that stretches the clock for S cycles lengthens the released time to reload+SYNC_STAGES+2+S cycles.
- R3: At the end of the acknowledge operation, the acknowledge-busy output drops and the interrupt flag sets in the same cycle. SCL is then pulled low again and held low in idle, and SDA is released.
- R4: An accepted stop request pulls SDA low and keeps SCL low. After SDA reads low, SCL stays low for a further reload+1 clocks and is then released. SCL is pulled for reload+SYNC_STAGES+2 cycles in total.
- R5: reload+1 clocks after SCL reads high, SDA is released. SDA is pulled for 2*reload+2*SYNC_STAGES+4+S cycles in total, where S is the clock-stretch length.
- R6: The stop-observed bit sets when SDA and SCL both read high. The stop-busy output drops and the interrupt flag sets reload+1 cycles later. Both lines are then released in idle.
- R7: A buffer write while an operation is busy sets the write-collision flag and leaves the buffer unchanged. A buffer write while idle loads the buffer.
- R8: The interrupt and write-collision flags stay set until their own clear strobes. The stop-observed bit clears when the next operation is accepted.
- R9: If both requests arrive in the same idle cycle, the acknowledge operation runs. A request that arrives while an operation is busy is dropped and never starts later.
- R10: After reset, both lines are released, both busy outputs and all flags are 0, and the buffer holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_reload | input | BRG_W | Baud counter reload; one period is reload+1 clocks |
| ack_go | input | 1 | Request strobe for an acknowledge operation |
| ack_val | input | 1 | Acknowledge bit to send (0 = ACK, 1 = NACK) |
| stop_go | input | 1 | Request strobe for a STOP operation |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | BUF_W | Transmit buffer write data |
| clr_irq | input | 1 | Clears the interrupt flag |
| clr_wcol | input | 1 | Clears the write-collision flag |
| scl_in | input | 1 | SCL line level as seen at the pin |
| sda_in | input | 1 | SDA line level as seen at the pin |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| ack_busy | output | 1 | Acknowledge operation in progress |
| stop_busy | output | 1 | STOP operation in progress |
| buf_q | output | BUF_W | Transmit buffer contents |
| irq_flag | output | 1 | Sticky completion flag |
| stop_seen | output | 1 | STOP observed on the lines |
| wcol_flag | output | 1 | Sticky write-collision flag |

## Verification
The bench builds the block with a 4-bit reload, the default two-stage synchronizer and an 8-bit buffer. It sweeps reload values 0 to 3 and 6, clock-stretch lengths 0, 1 and 3, and both acknowledge values. It measures every pulled and released phase against closed-form cycle counts. The short reload range reaches the single-cycle period, where the counter fires on its load value. The bench also runs acknowledges from both idle SCL levels, which exercises the synchronizer latency at the start of the low phase.

// File: rtl/i2cas_pkg.sv
package i2cas_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACK_LO,
      ST_ACK_REL,
      ST_ACK_HI,
      ST_STP_SDA,
      ST_STP_LO,
      ST_STP_REL,
      ST_STP_HI,
      ST_STP_FREE,
      ST_STP_TAIL
   } seq_state_t;
endpackage

// File: rtl/i2cas_sync.sv
module i2cas_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cas_sync: STAGES must be at least 2");
   end

   logic [W-1:0] ff [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff[i] <= '1;
         else if (i == 0) ff[i] <= d;
         else ff[i] <= ff[(i == 0) ? 0 : i-1];
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/i2cas_brg.sv
module i2cas_brg #(
   parameter int BRG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRG_W-1:0] reload,
   input  logic             run,
   output logic             tick
);
   if (BRG_W < 1) begin : g_bad_width
      $error("i2cas_brg: BRG_W must be at least 1");
   end

   logic [BRG_W-1:0] cnt;

   assign tick = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run || tick)      cnt <= reload;
      else                        cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/i2cas_fsm.sv
module i2cas_fsm
   import i2cas_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack_go,
   input  logic ack_val,
   input  logic stop_go,
   input  logic clr_irq,
   input  logic scl_s,
   input  logic sda_s,
   input  logic tick,
   output logic run,
   output logic busy,
   output logic ack_busy,
   output logic stop_busy,
   output logic scl_pull,
   output logic sda_pull,
   output logic irq_flag,
   output logic stop_seen
);
   seq_state_t st, st_d;
   logic ackdt_q, scl_hold;
   logic accept, done_ack, done_stp, set_seen;

   always_comb begin
      st_d = st; accept = 1'b0; done_ack = 1'b0; done_stp = 1'b0; set_seen = 1'b0;
      case (st)
         ST_IDLE: begin
            if (ack_go)       begin st_d = ST_ACK_LO;  accept = 1'b1; end
            else if (stop_go) begin st_d = ST_STP_SDA; accept = 1'b1; end
         end
         ST_ACK_LO:   if (tick) st_d = ST_ACK_REL;
         ST_ACK_REL:  if (scl_s) st_d = ST_ACK_HI;
         ST_ACK_HI:   if (tick) begin st_d = ST_IDLE; done_ack = 1'b1; end
         ST_STP_SDA:  if (!sda_s) st_d = ST_STP_LO;
         ST_STP_LO:   if (tick) st_d = ST_STP_REL;
         ST_STP_REL:  if (scl_s) st_d = ST_STP_HI;
         ST_STP_HI:   if (tick) st_d = ST_STP_FREE;
         ST_STP_FREE: if (sda_s && scl_s) begin st_d = ST_STP_TAIL; set_seen = 1'b1; end
         ST_STP_TAIL: if (tick) begin st_d = ST_IDLE; done_stp = 1'b1; end
         default:     st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; ackdt_q <= 1'b1; scl_hold <= 1'b0;
         irq_flag <= 1'b0; stop_seen <= 1'b0;
      end else begin
         st <= st_d;
         if (accept && ack_go) ackdt_q <= ack_val;
         if (done_ack) scl_hold <= 1'b1;
         else if (done_stp) scl_hold <= 1'b0;
         if (done_ack || done_stp) irq_flag <= 1'b1;
         else if (clr_irq) irq_flag <= 1'b0;
         if (set_seen) stop_seen <= 1'b1;
         else if (accept) stop_seen <= 1'b0;
      end
   end

   always_comb begin
      scl_pull = 1'b0; sda_pull = 1'b0;
      case (st)
         ST_IDLE:                   scl_pull = scl_hold;
         ST_ACK_LO:   begin scl_pull = 1'b1; sda_pull = !ackdt_q; end
         ST_ACK_REL, ST_ACK_HI:     sda_pull = !ackdt_q;
         ST_STP_SDA, ST_STP_LO: begin scl_pull = 1'b1; sda_pull = 1'b1; end
         ST_STP_REL, ST_STP_HI:     sda_pull = 1'b1;
         default: ;
      endcase
   end

   assign ack_busy  = (st == ST_ACK_LO) || (st == ST_ACK_REL) || (st == ST_ACK_HI);
   assign stop_busy = (st != ST_IDLE) && !ack_busy;
   assign busy      = (st != ST_IDLE);
   assign run       = ((st == ST_ACK_LO) && !scl_s) || (st == ST_ACK_HI) ||
                      (st == ST_STP_LO) || (st == ST_STP_HI) || (st == ST_STP_TAIL);

   // R1
   ack_data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_busy && $past(ack_busy)) |-> $stable(sda_pull));
   // R6
   stop_seen_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_seen) |-> ($past(sda_s) && $past(scl_s)));
   // R3
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (!busy && $past(busy)));
   // R9
   no_stop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_busy |=> !stop_busy);
endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq #(
   parameter int BRG_W       = 8,
   parameter int BUF_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BRG_W-1:0] brg_reload,
   input  logic             ack_go,
   input  logic             ack_val,
   input  logic             stop_go,
   input  logic             buf_wr,
   input  logic [BUF_W-1:0] buf_wdata,
   input  logic             clr_irq,
   input  logic             clr_wcol,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             scl_pull,
   output logic             sda_pull,
   output logic             ack_busy,
   output logic             stop_busy,
   output logic [BUF_W-1:0] buf_q,
   output logic             irq_flag,
   output logic             stop_seen,
   output logic             wcol_flag
);
   localparam int PIN_W = 2;

   if (BUF_W < 1) begin : g_bad_buf
      $error("i2c_ackstop_seq: BUF_W must be at least 1");
   end

   logic [PIN_W-1:0] pins_s;
   logic             run, tick, busy;

   i2cas_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(pins_s));

   i2cas_brg #(.BRG_W(BRG_W)) u_brg (
      .clk(clk), .rst_n(rst_n), .reload(brg_reload), .run(run), .tick(tick));

   i2cas_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ack_go(ack_go), .ack_val(ack_val),
      .stop_go(stop_go), .clr_irq(clr_irq), .scl_s(pins_s[1]), .sda_s(pins_s[0]),
      .tick(tick), .run(run), .busy(busy), .ack_busy(ack_busy),
      .stop_busy(stop_busy), .scl_pull(scl_pull), .sda_pull(sda_pull),
      .irq_flag(irq_flag), .stop_seen(stop_seen));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q     <= '0;
         wcol_flag <= 1'b0;
      end else begin
         if (buf_wr && busy) wcol_flag <= 1'b1;
         else if (clr_wcol)  wcol_flag <= 1'b0;
         if (buf_wr && !busy) buf_q <= buf_wdata;
      end
   end

   // R7
   buf_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && busy) |=> ($stable(buf_q) && wcol_flag));
endmodule

// File: tb/i2c_ackstop_seq_bench.sv
module i2c_ackstop_seq_bench;
   localparam int BW = 4;
   localparam int DW = 8;
   localparam int SY = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [BW-1:0] brg_reload = '0;
   logic ack_go = 0, ack_val = 0, stop_go = 0, buf_wr = 0, clr_irq = 0, clr_wcol = 0;
   logic [DW-1:0] buf_wdata = '0;
   logic stretch = 0;
   logic scl_in, sda_in, scl_pull, sda_pull, ack_busy, stop_busy, irq_flag, stop_seen, wcol_flag;
   logic [DW-1:0] buf_q;
   int total = 0, bad = 0;
   bit scl_free = 1;
   bit finished = 0;

   always #5 clk = ~clk;

   assign scl_in = ~(scl_pull | stretch);
   assign sda_in = ~sda_pull;

   i2c_ackstop_seq #(.BRG_W(BW), .BUF_W(DW), .SYNC_STAGES(SY)) u_i2c_ackstop_seq (
      .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .ack_go(ack_go), .ack_val(ack_val),
      .stop_go(stop_go), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .clr_irq(clr_irq),
      .clr_wcol(clr_wcol), .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull),
      .sda_pull(sda_pull), .ack_busy(ack_busy), .stop_busy(stop_busy), .buf_q(buf_q),
      .irq_flag(irq_flag), .stop_seen(stop_seen), .wcol_flag(wcol_flag));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_irq();
      @(negedge clk); clr_irq = 1;
      @(negedge clk); clr_irq = 0;
      chk(irq_flag == 0, "R8 irq clear", irq_flag, 0);
   endtask

   task automatic run_ack(input int r, input bit dt, input int s, input bit stop_try);
      int lo = 0, hi = 0, sda_bad = 0, left = 0, guard = 0, exp_lo;
      bit rel = 0;
      brg_reload = BW'(r);
      @(negedge clk); ack_val = dt; ack_go = 1;
      @(negedge clk); ack_go = 0;
      chk(ack_busy == 1 && stop_seen == 0, "R8 start clears stop_seen", stop_seen, 0);
      while (ack_busy && guard < 2000) begin
         if (scl_pull) lo++;
         else begin
            hi++;
            if (!rel) begin rel = 1; left = s; end
         end
         if (rel) begin
            if (left > 0) begin stretch = 1; left--; end
            else stretch = 0;
         end
         if (sda_pull !== !dt) sda_bad++;
         stop_go = (stop_try && guard == 1);
         guard++;
         @(negedge clk);
      end
      stretch = 0; stop_go = 0;
      exp_lo = r + 1 + (scl_free ? SY : 0);
      chk(lo == exp_lo, "R1 ack low phase", lo, exp_lo);
      chk(sda_bad == 0, "R1 ack data on SDA", sda_bad, 0);
      chk(hi == r + SY + 2 + s, "R2 ack released phase", hi, r + SY + 2 + s);
      chk(irq_flag == 1 && scl_pull == 1 && sda_pull == 0, "R3 ack end state",
          {irq_flag, scl_pull, sda_pull}, 3'b110);
      scl_free = 0;
      @(negedge clk); @(negedge clk);
      chk(stop_busy == 0 && ack_busy == 0, "R9 late request dropped", stop_busy, 0);
      chk(irq_flag == 1, "R8 irq sticky", irq_flag, 1);
      clear_irq();
   endtask

   task automatic run_stop(input int r, input int s, input bit ack_try);
      int scl_lo = 0, sda_lo = 0, seen = 0, len = 0, left = 0;
      bit rel = 0;
      brg_reload = BW'(r);
      @(negedge clk); stop_go = 1;
      @(negedge clk); stop_go = 0;
      while (stop_busy && len < 2000) begin
         if (ack_busy) seen += 1000;
         if (scl_pull) scl_lo++;
         else if (!rel) begin rel = 1; left = s; end
         if (rel) begin
            if (left > 0) begin stretch = 1; left--; end
            else stretch = 0;
         end
         if (sda_pull) sda_lo++;
         if (stop_seen) seen++;
         ack_go = (ack_try && len == 2);
         len++;
         @(negedge clk);
      end
      stretch = 0; ack_go = 0;
      chk(scl_lo == r + SY + 2, "R4 stop SCL low time", scl_lo, r + SY + 2);
      chk(sda_lo == 2*r + 2*SY + 4 + s, "R5 stop SDA low time", sda_lo, 2*r + 2*SY + 4 + s);
      chk(seen == r + 1, "R6 stop_seen to end", seen, r + 1);
      chk(len == 3*r + 3*SY + 6 + s, "R9 stop length", len, 3*r + 3*SY + 6 + s);
      chk(irq_flag == 1 && stop_seen == 1 && scl_pull == 0 && sda_pull == 0, "R6 stop end state",
          {irq_flag, stop_seen, scl_pull, sda_pull}, 4'b1100);
      scl_free = 1;
      @(negedge clk);
      chk(ack_busy == 0, "R9 late ack dropped", ack_busy, 0);
      clear_irq();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(scl_pull == 0 && sda_pull == 0 && ack_busy == 0 && stop_busy == 0 && irq_flag == 0 &&
          stop_seen == 0 && wcol_flag == 0 && buf_q == 0, "R10 reset state", 0, 0);
      rst_n = 1;
      @(negedge clk);
      buf_wr = 1; buf_wdata = 8'h3C;
      @(negedge clk); buf_wr = 0;
      chk(buf_q == 8'h3C && wcol_flag == 0, "R7 idle write", buf_q, 8'h3C);

      foreach (ra[i]) ;
      for (int ri = 0; ri < 5; ri++) begin
         for (int si = 0; si < 3; si++) begin
            int r, s;
            r = (ri == 4) ? 6 : ri;
            s = (si == 2) ? 3 : si;
            run_stop(r, s, (ri == 1 && si == 0));
            for (int d = 0; d < 2; d++) run_ack(r, d[0], s, (d == 1));
            run_ack(r, 0, s, 0);
         end
      end

      // R9 simultaneous requests
      brg_reload = 2;
      @(negedge clk); ack_go = 1; stop_go = 1; ack_val = 0;
      @(negedge clk); ack_go = 0; stop_go = 0;
      chk(ack_busy == 1 && stop_busy == 0, "R9 ack wins", {ack_busy, stop_busy}, 2'b10);
      // R7 collision during busy
      buf_wr = 1; buf_wdata = 8'hA5;
      @(negedge clk); buf_wr = 0;
      chk(wcol_flag == 1, "R7 collision flag", wcol_flag, 1);
      chk(buf_q == 8'h3C, "R7 buffer unchanged", buf_q, 8'h3C);
      while (ack_busy) @(negedge clk);
      chk(wcol_flag == 1, "R8 wcol sticky", wcol_flag, 1);
      @(negedge clk); clr_wcol = 1;
      @(negedge clk); clr_wcol = 0;
      chk(wcol_flag == 0, "R8 wcol clear", wcol_flag, 0);
      clear_irq();

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int ra [1];
endmodule